// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits one bit per clock, producing a signed product of twice that width. Every iteration it inspects the lowest remaining multiplier bit together with the bit retired by the previous shift. That pair decides whether the sign-extended multiplicand is added to the running upper half, subtracted from it, or left alone. An arithmetic right shift of the joined upper half and multiplier register then follows. Signed operands are consumed directly, so no conversion to magnitudes happens before or after.

A single adder serves both directions: subtraction feeds the bitwise complement of the multiplicand into it with a carry-in of one. A pulse on `start` while the unit is idle captures both operands. `done` pulses once when the last iteration has been written, and the product then stays on `product` until the next accepted `start`.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0, and `done` stays 0 until a `start` is accepted.
- R2: For every signed operand pair, `product` equals the signed product of `opA` (multiplier) and `opB` (multiplicand), as a `2*WIDTH`-bit two's-complement value. For example, -118 times -99 gives 11682.
- R3: `done` is high for exactly one clock cycle per operation. It rises after exactly `WIDTH` rising edges following the edge that accepted `start`.
- R4: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its original operands and the usual latency, and no extra `done` pulse appears.
- R5: The most negative operand values, including -2^(WIDTH-1) times -2^(WIDTH-1) = 2^(2*WIDTH-2), give the correct product with no internal overflow.
- R6: After `done`, `product` holds its value in every cycle until a new `start` is accepted.
- R7: A zero operand on either side gives a product of 0, and multiplying by +1 or -1 gives the other operand or its negation, sign-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation when the unit is idle |
| opA | input | WIDTH | Signed multiplier, captured with an accepted start |
| opB | input | WIDTH | Signed multiplicand, captured with an accepted start |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed product, held after done |

## Verification
The embedded checks assume that `start` is only seen as a one-cycle request. They also assume that operands matter only on the accepting edge, so the checks never look at `opA`/`opB` outside that edge. The stimulus holds `start` for a single cycle and changes operands only together with it. Within that rule it deliberately raises `start` mid-run to show that the request is dropped. The adder overflow check relies on the upper half staying within the range that the multiplicand bounds. The stimulus reaches that range's edges with directed pairs built from the most negative and most positive values, alongside seeded random pairs.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half and retired bit
    logic step;  // one recode/add/shift iteration
  } ctrlStrb_t;
endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ctrlStrb_t strb,
  output logic      done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic {IDLE, RUN} state_t;
  state_t state;
  logic [CW-1:0] iterCnt;
  logic lastIter;

  assign lastIter  = (state == RUN) && (iterCnt == LAST);
  assign strb.load = (state == IDLE) && start;
  assign strb.step = (state == RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= lastIter;
      case (state)
        IDLE: if (start) begin
          state   <= RUN;
          iterCnt <= '0;
        end
        RUN: begin
          if (lastIter) begin
            state   <= IDLE;
            iterCnt <= '0;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= LAST);

  // R4
  busy_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !lastIter) |=> !strb.load);

  // R3
  step_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !$past(strb.step)) |-> !done);
endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = WIDTH + 1;  // guard bit for -min multiplicand

  logic [AW-1:0]    accHi;
  logic [WIDTH-1:0] mqReg;
  logic             prevBit;
  logic [AW-1:0]    mcand;

  logic [1:0]    pairSel;
  logic [AW-1:0] addend;
  logic          carryIn;
  logic [AW-1:0] sumHi;

  assign pairSel = {mqReg[0], prevBit};

  always_comb begin
    addend  = '0;
    carryIn = 1'b0;
    case (pairSel)
      2'b01: addend = mcand;
      2'b10: begin
        addend  = ~mcand;
        carryIn = 1'b1;
      end
      default: addend = '0;
    endcase
  end

  assign sumHi = accHi + addend + {{(AW-1){1'b0}}, carryIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi   <= '0;
      mqReg   <= '0;
      prevBit <= 1'b0;
      mcand   <= '0;
    end else if (strb.load) begin
      accHi   <= '0;
      mqReg   <= opA;
      prevBit <= 1'b0;
      mcand   <= {opB[WIDTH-1], opB};
    end else if (strb.step) begin
      accHi   <= {sumHi[AW-1], sumHi[AW-1:1]};
      mqReg   <= {sumHi[0], mqReg[WIDTH-1:1]};
      prevBit <= mqReg[0];
    end
  end

  assign product = {accHi[WIDTH-1:0], mqReg};

  // R5
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && (accHi[AW-1] == addend[AW-1])) |-> (sumHi[AW-1] == accHi[AW-1]));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(product));

  // R2
  guard_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |-> (accHi[AW-1] == accHi[AW-2]));
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  ctrlStrb_t strb;

  booth_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  booth_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

  // R1
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strb.step));
endmodule

// File: tb/sim_booth_mul_seq.sv
module sim_booth_mul_seq;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic done;
  logic [2*W-1:0] product;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .opA(opA), .opB(opB), .done(done), .product(product)
  );

  function automatic logic signed [2*W-1:0] refMul(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = a;
    eb = b;
    return ea * eb;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one operation; optional mid-run start with other operands (R4)
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, input string req);
    int lat;
    logic [2*W-1:0] held;
    lat = 0;
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = b ^ 8'h5a;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 3) start = 1'b1;
      else start = 1'b0;
      if (done || lat > 4 * W) break;
    end
    start = 1'b0;
    check({req, " product"}, product, refMul(a, b));
    check("R3 latency", 16'(lat), 16'(W));
    held = product;
    @(posedge clk);
    @(negedge clk);
    check("R3 done one cycle", {15'd0, done}, 16'd0);
    check("R6 product hold", product, held);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done at reset", {15'd0, done}, 16'd0);
    check("R1 product at reset", product, 16'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 no done without start", {15'd0, done}, 16'd0);

    runMul(8'(-118), 8'(-99), 0, "R2");
    check("R2 known pair", product, 16'd11682);
    // R5 extremes
    runMul(8'h80, 8'h80, 0, "R5");
    check("R5 min*min", product, 16'd16384);
    runMul(8'h80, 8'h7f, 0, "R5");
    runMul(8'h7f, 8'h80, 0, "R5");
    runMul(8'h7f, 8'h7f, 0, "R5");
    runMul(8'hff, 8'h80, 0, "R5");
    runMul(8'h80, 8'hff, 0, "R5");
    // R7 zero and unit
    runMul(8'h00, 8'h93, 0, "R7");
    runMul(8'h93, 8'h00, 0, "R7");
    runMul(8'h01, 8'h93, 0, "R7");
    runMul(8'hff, 8'h93, 0, "R7");
    runMul(8'h55, 8'haa, 0, "R2");
    // R4 start during a run is dropped
    runMul(8'h3c, 8'hc5, 1, "R4");
    runMul(8'h80, 8'h01, 1, "R4");
    // R2 random pairs
    for (int i = 0; i < 3000; i++) begin
      runMul(8'($urandom), 8'($urandom), (i % 7) == 0, "R2");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule